// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small content-addressable store. A table of words, each with its own valid flag, is searched by content instead of by address. A search pattern register and a care-mask register set the search. Every stored word is tested against the pattern at the same time, but only in the bit positions where the mask holds a 1. Positions where the mask holds 0 are treated as equal whatever they contain.

A compare strobe captures the per-word results into a hit register in one clock. Software-like control logic then pulls the matching words out one by one. Each fetch request walks the hit register from the lowest index upward and returns one word with its index. The fetch then removes that word's hit bit. When no hit bits remain, a fetch completes with the hit flag low. Words are written or invalidated through a separate indexed write port.

Top module: `mcam_top`

## Requirements
- R1: After reset all valid flags, the hit register, the pattern and the mask are zero. `busy`, `done` and `fetch_hit` are low, and a fetch then completes with no hit.
- R2: A compare strobe accepted at a clock edge replaces the whole hit register at that edge. Bit i is set exactly when word i is valid and equals the pattern in every position where the mask bit is 1. The pattern and mask used are the register contents before that edge.
- R3: Mask bits of 0 exclude their positions from the test, and an all-zero mask makes every valid word hit.
- R4: A word written with `wr_valid`=0, or never written since reset, never hits.
- R5: Successive fetches return the hit words in rising index order. Each fetch returns `fetch_data` and `fetch_idx` of the lowest remaining hit and clears that hit bit.
- R6: A fetch request sampled while idle sets `busy` high for exactly one cycle. In the next cycle `busy` is low and `done` is high for one cycle, with the result on the fetch outputs.
- R7: A fetch with no hit bits left completes with `fetch_hit`=0 and `fetch_data` and `fetch_idx` both zero.
- R8: While `busy` is high, compare strobes and fetch requests are ignored. When both arrive in the same idle cycle, the compare is taken and the fetch is dropped.
- R9: With pattern 101111100 and mask 111000000, a stored 100111100 does not hit and a stored 101000011 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_ld | input | 1 | Load `pat_in` into the pattern register |
| pat_in | input | WIDTH | Search pattern |
| msk_ld | input | 1 | Load `msk_in` into the mask register |
| msk_in | input | WIDTH | Care mask, 1 = position compared |
| wr_en | input | 1 | Write strobe for the word table |
| wr_idx | input | IDX_W | Index written |
| wr_data | input | WIDTH | Word written |
| wr_valid | input | 1 | Valid flag stored with the word |
| cmp_go | input | 1 | Compare strobe, loads the hit register |
| fetch_req | input | 1 | Request the next hit word |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle fetch completion pulse |
| fetch_hit | output | 1 | Completed fetch returned a word |
| fetch_data | output | WIDTH | Returned word |
| fetch_idx | output | IDX_W | Index of the returned word |

## Verification
On every cycle, the in-line properties check the fetch handshake: `done` only after a `busy` cycle, never both at once, and a hit only with `done`. They also check that a returned index has its hit bit cleared, that the hit register gains bits only through an accepted compare, and that an all-zero mask yields hits equal to the valid set. Only the bench scenarios can show that the comparison result per word is the right one for a given pattern and mask. The same goes for the rising fetch order, the data returned, the effect of invalidation, and the dropping of strobes during a fetch.

// File: rtl/mcam_pkg.sv
`timescale 1ns/1ps
package mcam_pkg;

   // fetch sequencer state
   typedef enum logic {
      FETCH_IDLE = 1'b0,
      FETCH_RUN  = 1'b1
   } fetch_st_e;

endpackage

// File: rtl/mcam_store.sv
`timescale 1ns/1ps
module mcam_store #(
   parameter int WORDS = 8,
   parameter int WIDTH = 9,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [WIDTH-1:0]             wr_data,
   input  logic                         wr_valid,
   output logic [WORDS-1:0][WIDTH-1:0]  words_o,
   output logic [WORDS-1:0]             valid_o
);

   logic [WORDS-1:0][WIDTH-1:0] words_q;
   logic [WORDS-1:0]            valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words_q <= '0;
         valid_q <= '0;
      end else if (wr_en) begin
         words_q[wr_idx] <= wr_data;
         valid_q[wr_idx] <= wr_valid;
      end
   end

   assign words_o = words_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/mcam_compare.sv
`timescale 1ns/1ps
module mcam_compare #(
   parameter int WORDS = 8,
   parameter int WIDTH = 9
) (
   input  logic [WIDTH-1:0]             pat,
   input  logic [WIDTH-1:0]             msk,
   input  logic [WORDS-1:0][WIDTH-1:0]  words,
   input  logic [WORDS-1:0]             valid,
   output logic [WORDS-1:0]             hit_vec
);

   // one comparator row per stored word, all evaluated together
   for (genvar w = 0; w < WORDS; w++) begin : g_row
      logic [WIDTH-1:0] pos_ok;
      // a position passes if it agrees with the pattern or is masked off
      assign pos_ok     = ~(pat ^ words[w]) | ~msk;
      assign hit_vec[w] = valid[w] & (&pos_ok);
   end

endmodule

// File: rtl/mcam_fetch.sv
`timescale 1ns/1ps
module mcam_fetch
   import mcam_pkg::*;
#(
   parameter int WORDS = 8,
   parameter int WIDTH = 9,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmp_go,
   input  logic                         fetch_req,
   input  logic [WORDS-1:0]             hit_vec,
   input  logic [WORDS-1:0][WIDTH-1:0]  words,
   output logic                         busy,
   output logic                         done,
   output logic                         fetch_hit,
   output logic [WIDTH-1:0]             fetch_data,
   output logic [IDX_W-1:0]             fetch_idx
);

   fetch_st_e        st_q;
   logic [WORDS-1:0] hits_q;
   logic             cmp_take;
   logic             req_take;
   logic [IDX_W-1:0] low_idx;
   logic             any_hit;

   assign cmp_take = (st_q == FETCH_IDLE) && cmp_go;
   assign req_take = (st_q == FETCH_IDLE) && fetch_req && !cmp_go;

   // lowest set hit bit
   always_comb begin
      low_idx = '0;
      any_hit = 1'b0;
      for (int i = WORDS - 1; i >= 0; i--) begin
         if (hits_q[i]) begin
            low_idx = IDX_W'(i);
            any_hit = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= FETCH_IDLE;
         hits_q     <= '0;
         done       <= 1'b0;
         fetch_hit  <= 1'b0;
         fetch_data <= '0;
         fetch_idx  <= '0;
      end else begin
         done      <= 1'b0;
         fetch_hit <= 1'b0;
         unique case (st_q)
            FETCH_IDLE: begin
               if (cmp_take) begin
                  hits_q <= hit_vec;
               end else if (req_take) begin
                  st_q <= FETCH_RUN;
               end
            end
            FETCH_RUN: begin
               st_q <= FETCH_IDLE;
               done <= 1'b1;
               if (any_hit) begin
                  fetch_hit          <= 1'b1;
                  fetch_data         <= words[low_idx];
                  fetch_idx          <= low_idx;
                  hits_q[low_idx]    <= 1'b0;
               end else begin
                  fetch_data <= '0;
                  fetch_idx  <= '0;
               end
            end
            default: st_q <= FETCH_IDLE;
         endcase
      end
   end

   assign busy = (st_q == FETCH_RUN);

   // R6
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   // R6
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
   // R7
   hit_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hit |-> done);
   // R5
   fetched_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hit |-> !hits_q[fetch_idx]);
   // R2
   hits_only_by_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmp_take) |-> ((hits_q & ~$past(hits_q)) == '0));

endmodule

// File: rtl/mcam_top.sv
`timescale 1ns/1ps
module mcam_top #(
   parameter int WORDS = 8,
   parameter int WIDTH = 9,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pat_ld,
   input  logic [WIDTH-1:0] pat_in,
   input  logic             msk_ld,
   input  logic [WIDTH-1:0] msk_in,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             wr_valid,
   input  logic             cmp_go,
   input  logic             fetch_req,
   output logic             busy,
   output logic             done,
   output logic             fetch_hit,
   output logic [WIDTH-1:0] fetch_data,
   output logic [IDX_W-1:0] fetch_idx
);

   if (WORDS < 2) begin : g_bad_words
      $error("mcam_top: WORDS must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mcam_top: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0]            pat_q;
   logic [WIDTH-1:0]            msk_q;
   logic [WORDS-1:0][WIDTH-1:0] words;
   logic [WORDS-1:0]            valid;
   logic [WORDS-1:0]            hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_q <= '0;
         msk_q <= '0;
      end else begin
         if (pat_ld) pat_q <= pat_in;
         if (msk_ld) msk_q <= msk_in;
      end
   end

   mcam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .wr_valid (wr_valid),
      .words_o  (words),
      .valid_o  (valid)
   );

   mcam_compare #(.WORDS(WORDS), .WIDTH(WIDTH)) cmp_i (
      .pat     (pat_q),
      .msk     (msk_q),
      .words   (words),
      .valid   (valid),
      .hit_vec (hit_vec)
   );

   mcam_fetch #(.WORDS(WORDS), .WIDTH(WIDTH)) fetch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_go     (cmp_go),
      .fetch_req  (fetch_req),
      .hit_vec    (hit_vec),
      .words      (words),
      .busy       (busy),
      .done       (done),
      .fetch_hit  (fetch_hit),
      .fetch_data (fetch_data),
      .fetch_idx  (fetch_idx)
   );

   // R3
   zero_mask_all_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q == '0) |-> (hit_vec == valid));

endmodule

// File: tb/mcam_top_tb_top.sv
`timescale 1ns/1ps
module mcam_top_tb_top;

   localparam int WORDS = 8;
   localparam int WIDTH = 9;
   localparam int IDX_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pat_ld = 1'b0, msk_ld = 1'b0;
   logic [WIDTH-1:0] pat_in = '0, msk_in = '0;
   logic             wr_en = 1'b0, wr_valid = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0;
   logic [WIDTH-1:0] wr_data = '0;
   logic             cmp_go = 1'b0, fetch_req = 1'b0;
   logic             busy, done, fetch_hit;
   logic [WIDTH-1:0] fetch_data;
   logic [IDX_W-1:0] fetch_idx;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   mcam_top #(.WORDS(WORDS), .WIDTH(WIDTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .pat_ld(pat_ld), .pat_in(pat_in), .msk_ld(msk_ld), .msk_in(msk_in),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_valid(wr_valid),
      .cmp_go(cmp_go), .fetch_req(fetch_req),
      .busy(busy), .done(done), .fetch_hit(fetch_hit),
      .fetch_data(fetch_data), .fetch_idx(fetch_idx)
   );

   // bench-side model of the table
   logic [WIDTH-1:0] mdl_word [WORDS];
   logic [WORDS-1:0] mdl_valid = '0;

   // {pattern, mask, expected hit set}
   localparam logic [2*WIDTH+WORDS-1:0] VECS [0:6] = '{
      {9'h17C, 9'h1C0, 8'h46},
      {9'h17C, 9'h1FF, 8'h04},
      {9'h0AA, 9'h000, 8'h77},
      {9'h000, 9'h1FF, 8'h20},
      {9'h03C, 9'h03F, 8'h05},
      {9'h0AA, 9'h1FF, 8'h00},
      {9'h001, 9'h001, 8'h52}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [WIDTH-1:0] d, input bit v);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d; wr_valid = v;
      @(negedge clk);
      wr_en = 1'b0;
      mdl_word[idx] = d;
      mdl_valid[idx] = v;
   endtask

   task automatic set_pm(input logic [WIDTH-1:0] p, input logic [WIDTH-1:0] m);
      @(negedge clk);
      pat_ld = 1'b1; msk_ld = 1'b1; pat_in = p; msk_in = m;
      @(negedge clk);
      pat_ld = 1'b0; msk_ld = 1'b0;
   endtask

   task automatic compare();
      @(negedge clk);
      cmp_go = 1'b1;
      @(negedge clk);
      cmp_go = 1'b0;
   endtask

   // one fetch; checks the two-cycle handshake (R6)
   task automatic fetch(output bit h, output logic [WIDTH-1:0] d,
                        output logic [IDX_W-1:0] ix);
      @(negedge clk);
      fetch_req = 1'b1;
      @(negedge clk);
      fetch_req = 1'b0;
      chk(busy === 1'b1 && done === 1'b0, "R6", "busy after request",
          {busy, done}, 2'b10);
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b1, "R6", "done cycle",
          {busy, done}, 2'b01);
      h = fetch_hit; d = fetch_data; ix = fetch_idx;
   endtask

   // drain all hits and compare with expected set (R5)
   task automatic drain(input logic [WORDS-1:0] exp, input string req);
      logic [WORDS-1:0] got;
      int prev;
      bit h;
      logic [WIDTH-1:0] d;
      logic [IDX_W-1:0] ix;
      got = '0;
      prev = -1;
      for (int r = 0; r <= WORDS; r++) begin
         fetch(h, d, ix);
         if (!h) begin
            chk(d === '0 && ix === '0, "R7", "miss outputs zero", {d, ix}, 0);
            break;
         end
         chk(int'(ix) > prev, "R5", "rising order", ix, prev + 1);
         chk(d === mdl_word[ix], "R5", "fetched data", d, mdl_word[ix]);
         got[ix] = 1'b1;
         prev = int'(ix);
      end
      chk(got === exp, req, "hit set", got, exp);
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      bit h;
      logic [WIDTH-1:0] d;
      logic [IDX_W-1:0] ix;
      for (int i = 0; i < WORDS; i++) mdl_word[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy === 1'b0 && done === 1'b0 && fetch_hit === 1'b0, "R1",
          "outputs in reset", {busy, done, fetch_hit}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 compare with empty table, mask zero: nothing hits
      compare();
      fetch(h, d, ix);
      chk(h == 1'b0, "R1", "empty table hit", h, 0);
      chk(d === '0 && ix === '0, "R7", "miss data/index", {d, ix}, 0);

      // table load; index 3 invalid (R4), index 7 never written
      wr(0, 9'h13C, 1'b1);
      wr(1, 9'h143, 1'b1);
      wr(2, 9'h17C, 1'b1);
      wr(3, 9'h17C, 1'b0);
      wr(4, 9'h1FF, 1'b1);
      wr(5, 9'h000, 1'b1);
      wr(6, 9'h155, 1'b1);

      // vector table: R9 first entry, R4 second, R3 third, R2 rest
      for (int v = 0; v < 7; v++) begin
         set_pm(VECS[v][2*WIDTH+WORDS-1 -: WIDTH], VECS[v][WIDTH+WORDS-1 -: WIDTH]);
         compare();
         drain(VECS[v][WORDS-1:0], v == 0 ? "R9" : (v == 2 ? "R3" : "R2"));
      end

      // R8: strobes during busy are dropped
      set_pm(9'h17C, 9'h1C0);
      compare();
      set_pm(9'h17C, 9'h000);
      @(negedge clk);
      fetch_req = 1'b1;
      @(negedge clk);
      fetch_req = 1'b1;
      cmp_go = 1'b1;
      @(negedge clk);
      fetch_req = 1'b0;
      cmp_go = 1'b0;
      chk(done === 1'b1 && fetch_hit === 1'b1 && fetch_idx === 3'd1, "R8",
          "first fetch under strobes", {done, fetch_hit, fetch_idx}, 5'b11001);
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R8", "second request dropped",
          {busy, done}, 0);
      drain(8'h44, "R8");

      // R8: compare wins over fetch in the same idle cycle
      @(negedge clk);
      cmp_go = 1'b1;
      fetch_req = 1'b1;
      @(negedge clk);
      cmp_go = 1'b0;
      fetch_req = 1'b0;
      chk(busy === 1'b0, "R8", "fetch dropped on compare", busy, 0);
      // new compare with zero mask restarts the scan (R2, R3)
      fetch(h, d, ix);
      fetch(h, d, ix);
      compare();
      fetch(h, d, ix);
      chk(h && ix === 3'd0 && d === 9'h13C, "R2", "rescan restarts at 0",
          {h, ix}, 4'b1000);

      // R4: invalidate index 2, exact search finds nothing
      wr(2, 9'h17C, 1'b0);
      set_pm(9'h17C, 9'h1FF);
      compare();
      drain(8'h00, "R4");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule